// File: doc/BRIEF.md
# DMA Event Status Register with Interrupt

This block collects single-cycle event pulses that the receive DMA, the transmit DMA and the HDLC engines raise on behalf of many channels. Each event type owns one bit of a 16-bit status word. A pulse on that event line from any channel sets the bit, and the bit stays set until the host reads it. A status read returns the word one cycle later and clears every bit in the same edge. An event that arrives in the same cycle as that clearing read is kept.

A companion mask word selects which set bits may interrupt the host. When any enabled bit is set, a registered active-low PCI-style interrupt line is driven low. A second active-low line for the local bus follows the same condition, but only while the local bus is in configuration mode. The host reaches both words through a simple one-cycle register port with a single address bit.

Top module: `dma_evt_status`

## Requirements
- R1: After reset, the status and mask words read 0, `reg_rdata_o` is 0, and both `pci_int_no` and `lb_int_no` are high.
- R2: Bit positions are fixed. A high level on `chan_ev_i[c*16+b]` at a rising edge sets status bit b for any channel c. Bits 2 to 7 are receive CRC error, receive abort, receive length violation, receive FIFO overflow, large-buffer free-queue read (single or burst) and large-buffer free-queue empty on read. Bits 8 to 15 are small-buffer read, small-buffer read error, receive done-queue write, receive done-queue write error, transmit underflow, transmit pending-queue read, transmit done-queue write and transmit done-queue write error. Bits 0 and 1 are unused: they always read 0, and events on them are dropped.
- R3: A set status bit stays set over any number of cycles without a status read.
- R4: A read request (`reg_req_i`=1, `reg_we_i`=0) with `reg_addr_i`=0 places the status word on `reg_rdata_o` after the next edge and clears all bits in that edge. A read with `reg_addr_i`=1 returns the mask and leaves the status unchanged.
- R5: An event in the same cycle as a clearing status read is absent from the returned value and is set in the status afterwards.
- R6: A write with `reg_addr_i`=1 stores `reg_wdata_i` into the mask, and mask bits 0 and 1 read 0. A write with `reg_addr_i`=0 has no effect on the status.
- R7: `pci_int_no` goes low one cycle after (status AND mask) becomes nonzero. Set bits that are masked off do not drive it low.
- R8: `lb_int_no` is low only when the PCI interrupt condition holds and `lb_cfg_mode_i` was 1 at the same edge.
- R9: After a clearing status read, the interrupt lines return high one cycle after the status clears, unless new events arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chan_ev_i | input | NCHAN*16 | Event pulses, 16 per channel, channel c at bits c*16+15..c*16 |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 1 | 0 = status, 1 = mask |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, valid the cycle after a read |
| lb_cfg_mode_i | input | 1 | Local bus is in configuration mode |
| pci_int_no | output | 1 | Active-low host interrupt |
| lb_int_no | output | 1 | Active-low local-bus interrupt |

## Verification
A status bit that was lost or cleared at the wrong time first shows up in the value returned by the next status read. Its effect on the interrupt lines shows one edge after the bad status state. A wrong mask shows up on `pci_int_no` within two cycles of an event pulse. The sweep drives every bit on every channel, and each position is read back right after its pulse, so the first bad position or channel is the one reported.

// File: rtl/dmastat_pkg.sv
package dmastat_pkg;
    localparam int STAT_W  = 16;
    localparam int RSVD_LO = 2;

    typedef logic [STAT_W-1:0] stat_t;

    localparam stat_t USED_MASK = {{(STAT_W-RSVD_LO){1'b1}}, {RSVD_LO{1'b0}}};

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;

    typedef struct packed {
        stat_t mask;
        stat_t rdata;
    } host_state_t;

    typedef struct packed {
        logic pci;
        logic lb;
    } irq_state_t;
endpackage

// File: rtl/dmastat_chan_or.sv
module dmastat_chan_or
    import dmastat_pkg::*;
#(
    parameter int NCHAN = 4
) (
    input  logic [NCHAN*STAT_W-1:0] ev_i,
    output stat_t                   any_o
);
    for (genvar gb = 0; gb < STAT_W; gb++) begin : g_bit
        logic [NCHAN-1:0] col;
        for (genvar gc = 0; gc < NCHAN; gc++) begin : g_chan
            assign col[gc] = ev_i[gc*STAT_W + gb];
        end
        assign any_o[gb] = |col;
    end
endmodule

// File: rtl/dmastat_sticky.sv
module dmastat_sticky
    import dmastat_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  stat_t set_i,
    input  logic  clr_i,
    output stat_t stat_o
);
    stat_t stat_d, stat_q;

    always_comb begin
        stat_d = clr_i ? '0 : stat_q;
        stat_d = (stat_d | set_i) & USED_MASK;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stat_q <= '0;
        else         stat_q <= stat_d;
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/dmastat_irq.sv
module dmastat_irq
    import dmastat_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  stat_t stat_i,
    input  stat_t mask_i,
    input  logic  cfg_mode_i,
    output logic  pci_int_no,
    output logic  lb_int_no
);
    irq_state_t irq_d, irq_q;

    always_comb begin
        irq_d.pci = |(stat_i & mask_i);
        irq_d.lb  = irq_d.pci & cfg_mode_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) irq_q <= '0;
        else         irq_q <= irq_d;
    end

    assign pci_int_no = ~irq_q.pci;
    assign lb_int_no  = ~irq_q.lb;
endmodule

// File: rtl/dma_evt_status.sv
module dma_evt_status
    import dmastat_pkg::*;
#(
    parameter int NCHAN = 4
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [NCHAN*STAT_W-1:0] chan_ev_i,
    input  logic                    reg_req_i,
    input  logic                    reg_we_i,
    input  logic                    reg_addr_i,
    input  logic [STAT_W-1:0]       reg_wdata_i,
    output logic [STAT_W-1:0]       reg_rdata_o,
    input  logic                    lb_cfg_mode_i,
    output logic                    pci_int_no,
    output logic                    lb_int_no
);
    stat_t       ev_any_w;
    stat_t       stat_w;
    logic        rd_stat_w;
    logic        wr_mask_w;
    host_state_t host_d, host_q;

    assign rd_stat_w = reg_req_i & ~reg_we_i & (reg_sel_e'(reg_addr_i) == SEL_STATUS);
    assign wr_mask_w = reg_req_i &  reg_we_i & (reg_sel_e'(reg_addr_i) == SEL_MASK);

    dmastat_chan_or #(.NCHAN(NCHAN)) u_or (
        .ev_i  (chan_ev_i),
        .any_o (ev_any_w)
    );

    dmastat_sticky u_sticky (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (ev_any_w),
        .clr_i  (rd_stat_w),
        .stat_o (stat_w)
    );

    always_comb begin
        host_d = host_q;
        if (wr_mask_w) host_d.mask = reg_wdata_i & USED_MASK;
        if (reg_req_i && !reg_we_i) begin
            host_d.rdata = (reg_sel_e'(reg_addr_i) == SEL_STATUS) ? stat_w : host_q.mask;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) host_q <= '0;
        else         host_q <= host_d;
    end

    dmastat_irq u_irq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .stat_i     (stat_w),
        .mask_i     (host_q.mask),
        .cfg_mode_i (lb_cfg_mode_i),
        .pci_int_no (pci_int_no),
        .lb_int_no  (lb_int_no)
    );

    assign reg_rdata_o = host_q.rdata;
endmodule

// File: rtl/dmastat_chk.sv
module dmastat_chk
    import dmastat_pkg::*;
(
    input logic  clk_i,
    input logic  rst_ni,
    input stat_t ev_any,
    input logic  rd_stat,
    input stat_t stat,
    input stat_t mask,
    input logic  cfg_mode,
    input logic  pci_n,
    input logic  lb_n
);
    // R2: an event on a used bit is visible in status after the edge
    p_event_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((stat & $past(ev_any & USED_MASK)) == $past(ev_any & USED_MASK)));

    // R2: unused low bits never set
    p_unused_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat[RSVD_LO-1:0] == '0);

    // R3: no read, nothing drops
    p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_stat |=> ((stat & $past(stat)) == $past(stat)));

    // R4 / R5: after a status read only coincident events remain
    p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_stat |=> ((stat & ~$past(ev_any)) == '0));

    // R7 / R9: host line follows enabled status one edge later
    p_pci_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (pci_n == !(|$past(stat & mask))));

    // R8: local-bus line also needs configuration mode
    p_lb_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (lb_n == !((|$past(stat & mask)) && $past(cfg_mode))));
endmodule

bind dma_evt_status dmastat_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_any   (ev_any_w),
    .rd_stat  (rd_stat_w),
    .stat     (stat_w),
    .mask     (host_q.mask),
    .cfg_mode (lb_cfg_mode_i),
    .pci_n    (pci_int_no),
    .lb_n     (lb_int_no)
);

// File: tb/dma_evt_status_tb.sv
module dma_evt_status_tb;
    localparam int NCH = 4;
    localparam int W   = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH*W-1:0] ev = '0;
    logic            req = 1'b0, we = 1'b0, addr = 1'b0, cfg = 1'b0;
    logic [W-1:0]    wdata = '0;
    logic [W-1:0]    rdata;
    logic            pci_n, lb_n;
    int              n_run = 0, n_fail = 0;
    bit              done = 1'b0;

    always #2 clk = ~clk;

    dma_evt_status #(.NCHAN(NCH)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .chan_ev_i(ev),
        .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .lb_cfg_mode_i(cfg), .pci_int_no(pci_n), .lb_int_no(lb_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input int ch, input int b);
        @(negedge clk); ev[ch*W+b] = 1'b1;
        @(negedge clk); ev = '0;
    endtask

    task automatic rd(input logic a, output logic [W-1:0] v);
        @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk); req = 1'b0; v = rdata;
    endtask

    task automatic wr(input logic a, input logic [W-1:0] d);
        @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk); req = 1'b0; we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        repeat (3) @(negedge clk);
        chk("R1 rdata", rdata, 0);
        chk("R1 pci", pci_n, 1);
        chk("R1 lb", lb_n, 1);
        rst_n = 1'b1;
        rd(1'b0, v); chk("R1 status", v, 0);
        rd(1'b1, v); chk("R1 mask", v, 0);

        wr(1'b1, 16'hFFFF);
        rd(1'b1, v); chk("R6 mask readback", v, 16'hFFFC);
        pulse(0, 4);
        rd(1'b1, v); chk("R4 mask read keeps status", v, 16'hFFFC);
        rd(1'b0, v); chk("R4 status after mask read", v, 16'h0010);
        @(negedge clk);
        wr(1'b0, 16'hFFFF);
        rd(1'b0, v); chk("R6 status write ignored", v, 0);

        // R2 R7 R9 sweep: every bit on every channel, mask all on
        cfg = 1'b1;
        for (int ch = 0; ch < NCH; ch++) begin
            for (int b = 0; b < W; b++) begin
                logic [W-1:0] e;
                e = (b >= 2) ? W'(1 << b) : '0;
                pulse(ch, b);
                @(negedge clk);
                chk($sformatf("R7 pci ch%0d b%0d", ch, b), pci_n, (e == 0));
                chk($sformatf("R8 lb ch%0d b%0d", ch, b), lb_n, (e == 0));
                rd(1'b0, v);
                chk($sformatf("R2 status ch%0d b%0d", ch, b), v, e);
                @(negedge clk);
                chk($sformatf("R9 release ch%0d b%0d", ch, b), pci_n, 1);
            end
        end

        // R8: local-bus line stays high outside configuration mode
        cfg = 1'b0;
        pulse(2, 9);
        @(negedge clk);
        chk("R8 pci cfg0", pci_n, 0);
        chk("R8 lb cfg0", lb_n, 1);
        rd(1'b0, v); @(negedge clk);

        // R7: one mask bit at a time
        for (int b = 2; b < W; b++) begin
            int o;
            o = ((b - 1) % 14) + 2;
            wr(1'b1, W'(1 << b));
            pulse(1, o);
            @(negedge clk);
            chk($sformatf("R7 masked b%0d", o), pci_n, 1);
            rd(1'b0, v); @(negedge clk);
            pulse(3, b);
            @(negedge clk);
            chk($sformatf("R7 enabled b%0d", b), pci_n, 0);
            rd(1'b0, v); @(negedge clk);
        end

        // R3: bit held over many idle cycles
        pulse(0, 11);
        repeat (20) @(negedge clk);
        rd(1'b0, v); chk("R3 sticky", v, 16'h0800);

        // R5: event coincident with clearing read
        pulse(1, 3);
        @(negedge clk); req = 1'b1; we = 1'b0; addr = 1'b0; ev[2*W+5] = 1'b1;
        @(negedge clk); req = 1'b0; ev = '0; v = rdata;
        chk("R5 returned", v, 16'h0008);
        rd(1'b0, v); chk("R5 kept", v, 16'h0020);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule